// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps many hardware queues of descriptor indices. Every queue is a singly linked list threaded through one shared link RAM, and the RAM has one entry per descriptor index. Each queue holds a head pointer, a tail pointer and an entry count. Because of this, the total storage scales with the number of descriptors and not with the number of queues times a FIFO depth.

A producer, such as software or a DMA engine, appends a descriptor index to the tail of a queue through a push port. A consumer removes the index at the head of a queue through a pop port. One push and one pop may be issued in the same cycle. A count-read port returns the current depth of any queue. A contiguous range of queues drives one pend bit per queue. A pend bit is high while its queue holds anything, and these bits are meant to trigger DMA transmit channels or interrupt logic.

An index is `DW = log2(NDESC)+1` bits wide. The all-ones value is the null index and is never a valid descriptor.

Top module: `hwq_linkmgr`

## Requirements
- R1: After reset, every queue count reads 0, all `pend` bits are low and `pop_done` is low.
- R2: Pops from one queue return the indices pushed onto it in the order they were pushed (first in, first out).
- R3: A pop from an empty queue, with no push to that queue in the same cycle, returns the null index (all ones) and leaves that queue's count at 0.
- R4: `cnt_val` gives the count of queue `cnt_sel` in the same cycle. The count is pushes minus successful pops, and it never exceeds `NDESC`.
- R5: `pend[i]` is high exactly when queue `PEND_BASE+i` holds at least one index.
- R6: When a push and a pop target the same queue in one cycle, the push is applied first. On an empty queue, the pop returns the pushed index and the queue stays empty. On a non-empty queue, the head is returned and the count is unchanged.
- R7: A queue that no push or pop targets keeps its count and contents.
- R8: A push to one queue and a pop from a different queue in the same cycle both take effect.
- R9: `pop_done` is high in the cycle after each pop request, with the result on `pop_idx`, and is low after cycles without a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Push request this cycle |
| push_q | input | QW | Queue to append to |
| push_idx | input | DW | Descriptor index to append |
| pop_en | input | 1 | Pop request this cycle |
| pop_q | input | QW | Queue to pop from |
| pop_done | output | 1 | Pop result valid (one cycle after request) |
| pop_idx | output | DW | Popped index, or all ones if empty |
| cnt_sel | input | QW | Queue whose count is read |
| cnt_val | output | CW | Entry count of queue `cnt_sel` |
| pend | output | PEND_N | Non-empty flags for queues PEND_BASE.. |

## Verification
The assertions check on every cycle that a pop result follows each request, that an empty pop yields the null index, and that a non-empty pop yields a real one. They also check that a same-cycle push and pop on an empty queue hands back the pushed index, that counts stay bounded, and that an untouched queue's count holds. First-in-first-out order across long lists, pend tracking and the exact count arithmetic are shown only by the bench. It does this by comparing against a behavioural model of per-queue lists over directed corner cases, including the push-onto-single-entry bypass, and a long random mix of traffic.

// File: rtl/hwq_linkmgr.sv
module hwq_linkmgr #(
  parameter int NQ        = 16,
  parameter int NDESC     = 32,
  parameter int PEND_BASE = 4,
  parameter int PEND_N    = 4,
  localparam int QW = $clog2(NQ),
  localparam int LW = $clog2(NDESC),
  localparam int DW = LW + 1,
  localparam int CW = $clog2(NDESC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [QW-1:0]     push_q,
  input  logic [DW-1:0]     push_idx,
  input  logic              pop_en,
  input  logic [QW-1:0]     pop_q,
  output logic              pop_done,
  output logic [DW-1:0]     pop_idx,
  input  logic [QW-1:0]     cnt_sel,
  output logic [CW-1:0]     cnt_val,
  output logic [PEND_N-1:0] pend
);
  localparam logic [DW-1:0] NULL = '1;

  logic [DW-1:0] head [NQ];
  logic [DW-1:0] tail [NQ];
  logic [CW-1:0] cnt  [NQ];
  logic [DW-1:0] link [NDESC];

  logic [DW-1:0] pop_res, next_head;
  logic          same, pop_empty, push_live;

  assign same      = push_en && pop_en && (push_q == pop_q);
  assign pop_empty = (cnt[pop_q] == '0);
  assign push_live = push_en && !(same && pop_empty);
  assign cnt_val   = cnt[cnt_sel];

  always_comb begin
    if (!pop_empty)       pop_res = head[pop_q];
    else if (same)        pop_res = push_idx;
    else                  pop_res = NULL;
    if (same && cnt[pop_q] == CW'(1)) next_head = push_idx;
    else                              next_head = link[head[pop_q][LW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        head[i] <= NULL;
        tail[i] <= NULL;
        cnt[i]  <= '0;
      end
      pop_done <= 1'b0;
      pop_idx  <= NULL;
    end else begin
      pop_done <= pop_en;
      if (pop_en) pop_idx <= pop_res;
      if (push_live) begin
        if (cnt[push_q] == '0) head[push_q] <= push_idx;
        tail[push_q] <= push_idx;
      end
      if (pop_en && !pop_empty) head[pop_q] <= next_head;
      if (!same) begin
        if (push_en)               cnt[push_q] <= cnt[push_q] + CW'(1);
        if (pop_en && !pop_empty)  cnt[pop_q]  <= cnt[pop_q] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_live) begin
      if (cnt[push_q] != '0) link[tail[push_q][LW-1:0]] <= push_idx;
      link[push_idx[LW-1:0]] <= NULL;
    end
  end

  for (genvar g = 0; g < PEND_N; g++) begin : g_pend
    assign pend[g] = (cnt[PEND_BASE + g] != '0);
  end

  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> pop_done);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_en |=> !pop_done);
  a_r3_empty_null: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && pop_empty && !same) |=> (pop_idx == NULL));
  a_r2_nonempty_real: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !pop_empty) |=> (pop_idx != NULL));
  a_r6_bypass_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (same && pop_empty) |=> (pop_idx == $past(push_idx)));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_val <= CW'(NDESC));
  a_r7_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(push_en && push_q == cnt_sel) && !(pop_en && pop_q == cnt_sel))
    |=> (cnt_sel != $past(cnt_sel) || cnt_val == $past(cnt_val)));
endmodule

// File: tb/hwq_linkmgr_test.sv
module hwq_linkmgr_test;
  localparam int NQ = 16, NDESC = 32, PB = 4, PN = 4;
  localparam int QW = $clog2(NQ), DW = $clog2(NDESC) + 1, CW = $clog2(NDESC + 1);
  localparam int NULLV = (1 << DW) - 1;

  logic clk = 0, rst_n = 0;
  logic push_en = 0, pop_en = 0;
  logic [QW-1:0] push_q = '0, pop_q = '0, cnt_sel = '0;
  logic [DW-1:0] push_idx = '0;
  logic pop_done;
  logic [DW-1:0] pop_idx;
  logic [CW-1:0] cnt_val;
  logic [PN-1:0] pend;

  hwq_linkmgr #(.NQ(NQ), .NDESC(NDESC), .PEND_BASE(PB), .PEND_N(PN)) uut (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_q(push_q), .push_idx(push_idx),
    .pop_en(pop_en), .pop_q(pop_q), .pop_done(pop_done), .pop_idx(pop_idx),
    .cnt_sel(cnt_sel), .cnt_val(cnt_val), .pend(pend));

  always #5 clk = ~clk;

  int nchk = 0, nbad = 0, rot = 0;
  int model [NQ][$];
  bit inuse [NDESC];
  bit done_flag = 0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int q = 0; q < NQ; q++) begin
      cnt_sel = QW'(q);
      #0.1;
      chk(req, int'(cnt_val), model[q].size());
    end
  endtask

  task automatic step(string req, bit pe, int pq, int pd, bit oe, int oq);
    int exp;
    int pexp;
    @(negedge clk);
    push_en = pe; push_q = QW'(pq); push_idx = DW'(pd);
    pop_en = oe; pop_q = QW'(oq);
    if (pe) begin model[pq].push_back(pd); inuse[pd] = 1; end
    exp = NULLV;
    if (oe && model[oq].size() > 0) begin
      exp = model[oq].pop_front();
      inuse[exp] = 0;
    end
    @(posedge clk);
    #1;
    chk({req, "/R9 done"}, int'(pop_done), int'(oe));
    if (oe) chk({req, " pop"}, int'(pop_idx), exp);
    pexp = 0;
    for (int i = 0; i < PN; i++) if (model[PB + i].size() > 0) pexp |= (1 << i);
    chk("R5 pend", int'(pend), pexp);
    cnt_sel = QW'(rot % NQ);
    #1;
    chk("R4 count", int'(cnt_val), model[rot % NQ].size());
    rot++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pop_done", int'(pop_done), 0);
    chk("R1 pend", int'(pend), 0);
    sweep("R1 count");
    @(negedge clk); rst_n = 1;

    step("R3 empty", 0, 0, 0, 1, 3);
    chk("R3 count", int'(cnt_val), 0);
    for (int i = 0; i < 5; i++) step("R2 fill", 1, 2, 10 + i, 0, 0);
    for (int i = 0; i < 5; i++) step("R2 order", 0, 0, 0, 1, 2);
    step("R3 drained", 0, 0, 0, 1, 2);
    step("R5 pend on", 1, PB + 1, 3, 0, 0);
    step("R5 pend off", 0, 0, 0, 1, PB + 1);
    step("R6 same empty", 1, 7, 4, 1, 7);
    step("R6 same one", 1, 7, 5, 0, 0);
    step("R6 same one", 1, 7, 6, 1, 7);
    step("R6 same one after", 0, 0, 0, 1, 7);
    step("R6 fill", 1, 8, 1, 0, 0);
    step("R6 fill", 1, 8, 2, 0, 0);
    step("R6 same two", 1, 8, 7, 1, 8);
    step("R8 cross", 1, 9, 8, 1, 8);
    step("R8 cross", 0, 0, 0, 1, 8);
    step("R8 cross", 0, 0, 0, 1, 9);
    sweep("R7 idle sweep");

    for (int n = 0; n < 3000; n++) begin
      int pd, pq, oq;
      bit pe, oe;
      pd = -1;
      pe = ($urandom % 3) != 0;
      if (pe) begin
        int start = $urandom % NDESC;
        for (int k = 0; k < NDESC; k++)
          if (pd < 0 && !inuse[(start + k) % NDESC]) pd = (start + k) % NDESC;
        if (pd < 0) pe = 0;
      end
      pq = (n % 200 < 100) ? $urandom % 4 + PB - 1 : $urandom % NQ;
      oq = ($urandom % 4 == 0) ? pq : $urandom % NQ;
      oe = ($urandom % 2) != 0;
      step("R7 random", pe, pq, pe ? pd : 0, oe, oq);
    end
    sweep("R4 final sweep");
    for (int q = 0; q < NQ; q++)
      while (model[q].size() > 0) step("R2 drain", 0, 0, 0, 1, q);
    sweep("R3 all empty");
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule